// File: doc/BRIEF.md
# Multi-Segment Trip Decision Sequencer

This block is the decision stage of a DC line protection relay. A start-up trigger arms it after a suspected fault, and an upstream classifier then delivers one fault probability score per time segment. The segments close at 0.8 ms, 1.5 ms and 3.0 ms after inception, each at its window end plus one 20 µs sample period plus the processing time. The sequencer takes the scores strictly in segment order. The first score above a fixed threshold latches a breaker trip command and records which segment caused it.

When the first segment finds no fault, the decision moves on to the second segment and then to the third. A later, longer window therefore backs up an earlier miss inside the same relay, and no separate backup scheme is needed. When all three segments stay at or below the threshold, the event is reported as external and no trip is issued. A watchdog aborts the sequence and raises an error flag if an expected score does not arrive in time.

Top module: `seg_trip_sequencer`

## Requirements
- R1: After reset, `trip_o`, `fault_o`, `extern_o` and `timeout_o` are 0 and `trip_seg_o` is 0.
- R2: An accepted score that is strictly greater than `THRESH` (default 58981, which is 0.9 of full scale) sets `trip_o` and `fault_o` to 1 and sets `trip_seg_o` to the segment index (1, 2 or 3). These outputs change at the clock edge that samples the score. A score equal to `THRESH` does not trip.
- R3: Segments are accepted only in the order 1, 2, 3. A score carrying any index other than the one currently expected is ignored.
- R4: If segments 1, 2 and 3 are all accepted without a trip, `extern_o` goes to 1 at the edge that samples the segment-3 score, `trip_o` stays 0, and the sequencer returns to idle.
- R5: Once set, `trip_o`, `fault_o` and `trip_seg_o` hold their values until `rst`, whatever arrives on the trigger and score inputs.
- R6: A `start_i` pulse while a sequence is in progress is ignored: the expected segment does not return to 1.
- R7: In a sequence, if no score for the expected segment is accepted within `TIMEOUT_CYC` consecutive cycles, `timeout_o` goes to 1 and the sequencer returns to idle. A score sampled in the `TIMEOUT_CYC`-th cycle is still accepted. The count restarts after each accepted segment.
- R8: Scores presented while idle are ignored and cause no trip.
- R9: A `start_i` pulse accepted from idle clears `extern_o` and `timeout_o` and expects segment 1 next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the only way to clear a trip |
| start_i | input | 1 | Start-up trigger; arms a sequence when idle |
| score_valid_i | input | 1 | Strobe for the score and its segment index |
| score_seg_i | input | SEG_W | Segment index of the score, 1 to NUM_SEG |
| score_i | input | SCORE_W | Unsigned fault probability score, full scale = 1.0 |
| trip_o | output | 1 | Latched breaker trip command |
| fault_o | output | 1 | Internal fault found |
| extern_o | output | 1 | All segments finished without a fault; the event was external |
| timeout_o | output | 1 | A sequence was aborted by the watchdog |
| trip_seg_o | output | SEG_W | Segment that caused the trip; 0 when there was no trip |

## Verification
A wrong expected-segment register shows up at the ports as a trip or an external verdict for the wrong segment, or as a missing one. The bench sees it at the first edge that samples a score with the mismatched index. A stuck or mis-reset watchdog count shows up exactly one cycle early or late on `timeout_o`, so the bench probes the last allowed cycle and the cycle after it. A state register that leaves the tripped state shows up as `trip_o` dropping or as an external verdict after a trip, and the bench feeds further scores and triggers after a trip to expose this.

// File: rtl/trip_seq_pkg.sv
package trip_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TRIP = 2'd2
  } seq_state_t;
endpackage

// File: rtl/trip_score_cmp.sv
// Strict greater-than comparison of a score against a fixed threshold.
module trip_score_cmp #(
  parameter int SCORE_W = 16,
  parameter int THRESH  = 58981
) (
  input  logic [SCORE_W-1:0] score,
  output logic               over
);
  localparam logic [SCORE_W-1:0] THR = SCORE_W'(THRESH);
  assign over = (score > THR);
endmodule

// File: rtl/trip_watchdog.sv
// Counts waiting cycles; expire is high in the last allowed cycle when no score is accepted.
module trip_watchdog #(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (run)       cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);
endmodule

// File: rtl/seg_trip_sequencer.sv
module seg_trip_sequencer
  import trip_seq_pkg::*;
#(
  parameter int SCORE_W     = 16,
  parameter int NUM_SEG     = 3,
  parameter int THRESH      = 58981,
  parameter int TIMEOUT_CYC = 4096,
  localparam int SEG_W      = $clog2(NUM_SEG + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               score_valid_i,
  input  logic [SEG_W-1:0]   score_seg_i,
  input  logic [SCORE_W-1:0] score_i,
  output logic               trip_o,
  output logic               fault_o,
  output logic               extern_o,
  output logic               timeout_o,
  output logic [SEG_W-1:0]   trip_seg_o
);
  localparam logic [SEG_W-1:0] FINAL_SEG = SEG_W'(NUM_SEG);

  seq_state_t       state;
  logic [SEG_W-1:0] exp_seg;
  logic [NUM_SEG-1:0] seg_hit;
  logic             accept;
  logic             over;
  logic             expire;

  // One decoder per segment: hit when the strobe carries the expected index.
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign seg_hit[s] = score_valid_i
                        && (score_seg_i == SEG_W'(s + 1))
                        && (exp_seg == SEG_W'(s + 1));
  end

  assign accept = (state == ST_WAIT) && (|seg_hit);

  trip_score_cmp #(.SCORE_W(SCORE_W), .THRESH(THRESH)) u_cmp (
    .score (score_i),
    .over  (over)
  );

  trip_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .run     ((state == ST_WAIT) && !accept),
    .restart ((state != ST_WAIT) || accept),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      exp_seg    <= '0;
      trip_o     <= 1'b0;
      fault_o    <= 1'b0;
      extern_o   <= 1'b0;
      timeout_o  <= 1'b0;
      trip_seg_o <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state     <= ST_WAIT;
            exp_seg   <= SEG_W'(1);
            extern_o  <= 1'b0;
            timeout_o <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (accept) begin
            if (over) begin
              state      <= ST_TRIP;
              trip_o     <= 1'b1;
              fault_o    <= 1'b1;
              trip_seg_o <= exp_seg;
            end else if (exp_seg == FINAL_SEG) begin
              state    <= ST_IDLE;
              exp_seg  <= '0;
              extern_o <= 1'b1;
            end else begin
              exp_seg <= exp_seg + 1'b1;
            end
          end else if (expire) begin
            state     <= ST_IDLE;
            exp_seg   <= '0;
            timeout_o <= 1'b1;
          end
        end
        default: state <= ST_TRIP;
      endcase
    end
  end
endmodule

// File: rtl/trip_seq_checker.sv
module trip_seq_checker #(
  parameter int SCORE_W = 16,
  parameter int SEG_W   = 2,
  parameter int NUM_SEG = 3,
  parameter int THRESH  = 58981
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               score_valid_i,
  input logic [SEG_W-1:0]   score_seg_i,
  input logic [SCORE_W-1:0] score_i,
  input logic               trip_o,
  input logic               fault_o,
  input logic               extern_o,
  input logic               timeout_o,
  input logic [SEG_W-1:0]   trip_seg_o
);
  AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_o) |-> $past(score_valid_i && (score_i > SCORE_W'(THRESH)))); // R2
  AST_TRIP_WITH_FAULT: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_o) |-> fault_o && (trip_seg_o != '0)); // R2
  AST_SEG_RANGE: assert property (@(posedge clk) disable iff (rst)
    trip_o |-> (trip_seg_o <= SEG_W'(NUM_SEG))); // R3
  AST_EXT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(extern_o) |-> $past(score_valid_i && (score_seg_i == SEG_W'(NUM_SEG))
                              && (score_i <= SCORE_W'(THRESH)))); // R4
  AST_EXT_NO_TRIP: assert property (@(posedge clk) disable iff (rst)
    !(extern_o && trip_o)); // R4
  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (rst)
    trip_o |=> trip_o && fault_o && $stable(trip_seg_o)); // R5
  AST_TIMEOUT_NO_TRIP: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |-> !trip_o); // R7
endmodule

bind seg_trip_sequencer trip_seq_checker #(
  .SCORE_W(SCORE_W), .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .THRESH(THRESH)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .score_valid_i(score_valid_i),
  .score_seg_i(score_seg_i), .score_i(score_i), .trip_o(trip_o),
  .fault_o(fault_o), .extern_o(extern_o), .timeout_o(timeout_o),
  .trip_seg_o(trip_seg_o)
);

// File: tb/test_seg_trip_sequencer.sv
`timescale 1ns/1ps
module test_seg_trip_sequencer;
  localparam int SCORE_W = 16;
  localparam int NUM_SEG = 3;
  localparam int THRESH  = 58981;
  localparam int TMO     = 12;
  localparam int SEG_W   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic score_valid_i = 1'b0;
  logic [SEG_W-1:0] score_seg_i = '0;
  logic [SCORE_W-1:0] score_i = '0;
  logic trip_o, fault_o, extern_o, timeout_o;
  logic [SEG_W-1:0] trip_seg_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  seg_trip_sequencer #(
    .SCORE_W(SCORE_W), .NUM_SEG(NUM_SEG), .THRESH(THRESH), .TIMEOUT_CYC(TMO)
  ) i_seg_trip_sequencer (
    .clk(clk), .rst(rst), .start_i(start_i), .score_valid_i(score_valid_i),
    .score_seg_i(score_seg_i), .score_i(score_i), .trip_o(trip_o),
    .fault_o(fault_o), .extern_o(extern_o), .timeout_o(timeout_o),
    .trip_seg_o(trip_seg_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cyc();
    cyc();
    rst = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    cyc();
    start_i = 1'b0;
  endtask

  task automatic send(input int seg, input int val);
    score_valid_i = 1'b1;
    score_seg_i   = SEG_W'(seg);
    score_i       = SCORE_W'(val);
    cyc();
    score_valid_i = 1'b0;
  endtask

  // Watchdog on the bench itself.
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vals[5];
    vals[0] = 0; vals[1] = THRESH - 1; vals[2] = THRESH;
    vals[3] = THRESH + 1; vals[4] = 65535;

    do_reset();
    // R1: reset state
    chk("R1 trip", int'(trip_o), 0);
    chk("R1 fault", int'(fault_o), 0);
    chk("R1 extern", int'(extern_o), 0);
    chk("R1 timeout", int'(timeout_o), 0);
    chk("R1 seg", int'(trip_seg_o), 0);

    // R8: scores while idle are ignored
    send(1, 65535);
    chk("R8 idle score no trip", int'(trip_o), 0);

    // Sweep: each target segment against each boundary value (R2, R4)
    for (int tgt = 1; tgt <= NUM_SEG; tgt++) begin
      for (int v = 0; v < 5; v++) begin
        do_reset();
        pulse_start();
        for (int s = 1; s < tgt; s++) send(s, vals[v] % 1000);
        send(tgt, vals[v]);
        if (vals[v] > THRESH) begin
          chk("R2 trip", int'(trip_o), 1);
          chk("R2 fault", int'(fault_o), 1);
          chk("R2 seg", int'(trip_seg_o), tgt);
          chk("R2 no extern", int'(extern_o), 0);
        end else begin
          chk("R2 no trip at/below thresh", int'(trip_o), 0);
          for (int s = tgt + 1; s <= NUM_SEG; s++) send(s, THRESH);
          chk("R4 extern", int'(extern_o), 1);
          chk("R4 trip", int'(trip_o), 0);
          chk("R4 seg", int'(trip_seg_o), 0);
        end
      end
    end

    // R3: out-of-order index ignored
    do_reset();
    pulse_start();
    send(2, 65535);
    chk("R3 wrong seg ignored", int'(trip_o), 0);
    send(3, 65535);
    chk("R3 wrong seg ignored 3", int'(trip_o), 0);
    send(1, 100);
    send(3, 100);
    chk("R3 seg3 before seg2 ignored", int'(extern_o), 0);
    send(2, 65535);
    chk("R3 seg2 trips", int'(trip_seg_o), 2);

    // R5: trip holds against further inputs
    pulse_start();
    send(1, 0);
    send(2, 0);
    send(3, 0);
    chk("R5 trip held", int'(trip_o), 1);
    chk("R5 seg held", int'(trip_seg_o), 2);
    chk("R5 no extern", int'(extern_o), 0);
    repeat (TMO + 3) cyc();
    chk("R5 no timeout while tripped", int'(timeout_o), 0);
    chk("R5 fault held", int'(fault_o), 1);

    // R6: trigger while busy ignored
    do_reset();
    pulse_start();
    send(1, 10);
    pulse_start();
    send(1, 65535);
    chk("R6 restart ignored, seg1 not expected", int'(trip_o), 0);
    send(2, 65535);
    chk("R6 seg2 still expected", int'(trip_seg_o), 2);

    // R7: watchdog expiry exactly after TMO cycles
    do_reset();
    pulse_start();
    repeat (TMO - 1) cyc();
    chk("R7 no timeout before limit", int'(timeout_o), 0);
    cyc();
    chk("R7 timeout at limit", int'(timeout_o), 1);
    send(1, 65535);
    chk("R7 idle after timeout", int'(trip_o), 0);

    // R9: new start clears timeout; R7 last allowed cycle accepted, count restarts
    pulse_start();
    chk("R9 timeout cleared", int'(timeout_o), 0);
    repeat (TMO - 1) cyc();
    send(1, 5);
    chk("R7 last-cycle score accepted", int'(timeout_o), 0);
    repeat (TMO - 1) cyc();
    send(2, 5);
    chk("R7 count restarted", int'(timeout_o), 0);
    send(3, 5);
    chk("R7 sequence completes", int'(extern_o), 1);
    pulse_start();
    chk("R9 extern cleared", int'(extern_o), 0);
    send(1, 65535);
    chk("R9 seg1 expected", int'(trip_seg_o), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule